// File: doc/BRIEF.md
# Serial Register Access Port

This block is a synchronous serial slave that gives a host read and write access to a bank of 8-bit registers. The host pulls chip-select low and clocks in a command byte followed by data bytes. Bits travel least significant first in both directions. The slave samples input on the rising serial clock edge and changes its output on the falling edge. The data output comes as a value plus an output enable, so that a pad or the integration level can build the tri-state driver. Because the enable is low during writes, the host may join its input and output lines.

The command byte carries, in transmit order, a read flag (0 write, 1 read), a four-bit register address (address LSB first), two bits that must be zero, and a burst flag. With the burst flag set and address zero, the transfer walks every register from address 0 upward, one byte each, and stops after the last one. Address 0 is a read-only status register that shows the `statusIn` port. Addresses 1 to 13 are read/write control registers. Some of their bit positions are reserved and always hold zero.

The serial pins are resynchronised into the system clock domain, and the register bank lives in that domain. The control registers reach the rest of the chip as one flat vector. The status value is sampled from `statusIn` in the same domain when a read loads it.

Top module: `ser_reg_port`

## Requirements
- R1: After reset, every read/write register reads zero and `sdoOe` is low.
- R2: A write command (bit 0 = 0, address in bits 1 to 4, bit 1 the address LSB) followed by eight data bits sent LSB first stores that byte in the addressed register.
- R3: A register changes only after the eighth data bit has been sampled. Raising chip-select after seven data bits leaves it unchanged.
- R4: A read command (bit 0 = 1) makes the addressed register appear on `sdo`, LSB first, one bit per falling serial clock edge, with `sdoOe` high through the data byte.
- R5: `sdoOe` is low while chip-select is high, during the command byte and during write transfers.
- R6: A command byte with either of bits 5 and 6 set is ignored: no register changes and `sdoOe` stays low.
- R7: Reserved bits always read zero, whatever value is written: bits 7 and 6 of register 5, and bit 7 of register 6.
- R8: Address 0 reads the value of `statusIn`. A write to address 0 changes no register.
- R9: A command with burst flag (bit 7) set and address 0 transfers addresses 0, 1, … 13 in order, one byte each, for reads and writes alike.
- R10: When the burst flag is set with a nonzero address, exactly one byte is transferred, at that address.
- R11: After the last register of a burst, further serial clocks are ignored: no write occurs and `sdoOe` is low until chip-select rises.
- R12: Addresses 14 and 15 hold nothing: writes change no register and reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the registers and the serial pin synchronisers run on it |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip-select from the host |
| sclk | input | 1 | Serial clock from the host, much slower than `clk` |
| sdi | input | 1 | Serial data in, sampled on rising `sclk` |
| statusIn | input | 8 | Value returned when address 0 is read |
| sdo | output | 1 | Serial data out, changes after falling `sclk` |
| sdoOe | output | 1 | Output enable for `sdo`; low means high impedance |
| regOut | output | 104 | Registers 1 to 13, register 1 in bits 7:0 |

## Verification
A wrong bit counter or phase shows up at once. The first wrong byte either lands in a neighbouring register on `regOut` or appears on `sdo` shifted by one position, within a single byte time. A wrong burst address counter shows up when the register is read back: values sit one address off, or a register beyond the last one is written. A stuck or late output enable shows as `sdoOe` high during a command or write, or low during a read, and it is observed on the very next serial bit.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  // strobes from control to datapath, all valid for one clk cycle
  typedef struct packed {
    logic              wrEn;
    logic              loadTx;
    logic              shiftTx;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wrData;
  } strobe_t;

  // bits that always hold zero in each register
  function automatic logic [DATA_W-1:0] rsvMask(input int a);
    case (a)
      5:       return 8'hC0;
      6:       return 8'h80;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ser_reg_ctrl.sv
module ser_reg_ctrl
  import ser_reg_pkg::*;
#(
  parameter int NUM_REGS = 14
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sclk,
  input  logic    sdi,
  output strobe_t strobe,
  output logic    sdoOe
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic [1:0] csSync;
  logic [2:0] sclkSync;
  logic [1:0] sdiSync;
  logic csHigh, sclkRise, sclkFall, sdiBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= 2'b11;
      sclkSync <= 3'b111;
      sdiSync  <= 2'b00;
    end else begin
      csSync   <= {csSync[0], csN};
      sclkSync <= {sclkSync[1:0], sclk};
      sdiSync  <= {sdiSync[0], sdi};
    end
  end

  assign csHigh   = csSync[1];
  assign sdiBit   = sdiSync[1];
  assign sclkRise = sclkSync[1] & ~sclkSync[2];
  assign sclkFall = ~sclkSync[1] & sclkSync[2];

  phase_e phase;
  logic [2:0]        bitCnt;
  logic [DATA_W-1:0] cmdSh, rxSh;
  logic [ADDR_W-1:0] addr;
  logic              isRead, isBurst;
  logic [DATA_W-1:0] cmdNext, rxNext;
  logic [ADDR_W-1:0] cmdAddr;

  assign cmdNext = {sdiBit, cmdSh[DATA_W-1:1]};
  assign rxNext  = {sdiBit, rxSh[DATA_W-1:1]};
  assign cmdAddr = cmdNext[ADDR_W:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_CMD;
      bitCnt  <= '0;
      cmdSh   <= '0;
      rxSh    <= '0;
      addr    <= '0;
      isRead  <= 1'b0;
      isBurst <= 1'b0;
    end else if (csHigh) begin
      phase   <= PH_CMD;
      bitCnt  <= '0;
      isRead  <= 1'b0;
      isBurst <= 1'b0;
    end else if (sclkRise) begin
      bitCnt <= bitCnt + 3'd1;
      case (phase)
        PH_CMD: begin
          cmdSh <= cmdNext;
          if (bitCnt == 3'd7) begin
            if (cmdNext[6:5] != 2'b00) begin
              phase <= PH_DONE;
            end else begin
              phase   <= PH_DATA;
              addr    <= cmdAddr;
              isRead  <= cmdNext[0];
              isBurst <= cmdNext[7] && (cmdAddr == '0);
            end
          end
        end
        PH_DATA: begin
          rxSh <= rxNext;
          if (bitCnt == 3'd7) begin
            if (isBurst && addr != LAST_ADDR) addr <= addr + 1'b1;
            else                               phase <= PH_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.addr    = addr;
    strobe.wrData  = rxNext;
    strobe.wrEn    = !csHigh && sclkRise && phase == PH_DATA && bitCnt == 3'd7 && !isRead;
    strobe.loadTx  = !csHigh && sclkFall && phase == PH_DATA && isRead && bitCnt == 3'd0;
    strobe.shiftTx = !csHigh && sclkFall && phase == PH_DATA && isRead && bitCnt != 3'd0;
  end

  assign sdoOe = !csHigh && phase == PH_DATA && isRead;

  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> !sdoOe); // R5
  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe |-> !strobe.wrEn); // R5
  AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE) |-> (!strobe.wrEn && !sdoOe)); // R11
  AST_CMD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CMD) |-> !strobe.wrEn); // R3
endmodule

// File: rtl/ser_reg_dp.sv
module ser_reg_dp
  import ser_reg_pkg::*;
#(
  parameter int NUM_REGS = 14
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strobe,
  input  logic [DATA_W-1:0]              statusIn,
  output logic                           sdo,
  output logic [(NUM_REGS-1)*DATA_W-1:0] regOut
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] txSh;
  logic [DATA_W-1:0] rdVal;

  generate
    for (genvar g = 1; g < NUM_REGS; g++) begin : gen_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          regs[g] <= '0;
        else if (strobe.wrEn && int'(strobe.addr) == g)
          regs[g] <= strobe.wrData & ~rsvMask(g);
      end
      assign regOut[(g-1)*DATA_W +: DATA_W] = regs[g];

      AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        (regs[g] & rsvMask(g)) == '0); // R7
    end
  endgenerate

  assign regs[0] = '0;

  always_comb begin
    if (strobe.addr == '0)                 rdVal = statusIn;
    else if (int'(strobe.addr) < NUM_REGS) rdVal = regs[strobe.addr];
    else                                   rdVal = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                txSh <= '0;
    else if (strobe.loadTx)   txSh <= rdVal;
    else if (strobe.shiftTx)  txSh <= {1'b0, txSh[DATA_W-1:1]};
  end

  assign sdo = txSh[0];

  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.addr == '0) |=> $stable(regOut)); // R8
  AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && int'(strobe.addr) >= NUM_REGS) |=> $stable(regOut)); // R12
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import ser_reg_pkg::*;
#(
  parameter int NUM_REGS = 14
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           csN,
  input  logic                           sclk,
  input  logic                           sdi,
  input  logic [DATA_W-1:0]              statusIn,
  output logic                           sdo,
  output logic                           sdoOe,
  output logic [(NUM_REGS-1)*DATA_W-1:0] regOut
);
  strobe_t strobe;

  ser_reg_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .strobe(strobe), .sdoOe(sdoOe)
  );

  ser_reg_dp #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusIn(statusIn),
    .sdo(sdo), .regOut(regOut)
  );
endmodule

// File: tb/ser_reg_port_bench.sv
module ser_reg_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8 * CLK_PERIOD;
  localparam int NREG = 14;
  localparam int WDOG = 100000;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [7:0] statusIn = 8'h5C;
  logic sdo, sdoOe;
  logic [(NREG-1)*8-1:0] regOut;

  int nChk = 0, nFail = 0;
  bit finished = 0;
  logic [7:0] expR [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_reg_port #(.NUM_REGS(NREG)) u_ser_reg_port (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .statusIn(statusIn), .sdo(sdo), .sdoOe(sdoOe), .regOut(regOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] getReg(input int k);
    return regOut[(k-1)*8 +: 8];
  endfunction

  function automatic logic [7:0] keepMask(input int k);
    if (k == 5) return 8'h3F;
    if (k == 6) return 8'h7F;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] mkCmd(input bit rd, input int a, input bit burst, input logic [1:0] rsv);
    return {burst, rsv, 4'(a), rd};
  endfunction

  task automatic checkAll(input string tag);
    for (int k = 1; k < NREG; k++) chk(tag, getReg(k), expR[k]);
  endtask

  task automatic sel();
    csN = 1'b0; #(HALF);
  endtask

  task automatic desel();
    csN = 1'b1; #(HALF*3);
  endtask

  task automatic doBits(input logic [7:0] wb, input int n, output logic [7:0] rb,
                        output logic oeAll, output logic oeAny);
    rb = '0; oeAll = 1'b1; oeAny = 1'b0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; sdi = wb[i];
      #(HALF-20);
      rb[i] = sdo; oeAll &= sdoOe; oeAny |= sdoOe;
      #20;
      sclk = 1'b1;
      #(HALF);
    end
  endtask

  task automatic writeOne(input logic [7:0] cmd, input logic [7:0] val, output logic oeAny);
    logic [7:0] rb; logic oa, o1, o2;
    sel();
    doBits(cmd, 8, rb, oa, o1);
    doBits(val, 8, rb, oa, o2);
    desel();
    oeAny = o1 | o2;
  endtask

  task automatic readOne(input logic [7:0] cmd, output logic [7:0] val, output logic oeAll);
    logic [7:0] rb; logic oa, oy;
    sel();
    doBits(cmd, 8, rb, oa, oy);
    doBits(8'h00, 8, val, oeAll, oy);
    desel();
  endtask

  task automatic t_reset();
    checkAll("R1 reset value");
    chk("R1 oe after reset", sdoOe, 1'b0);
    chk("R5 oe with cs high", sdoOe, 1'b0);
  endtask

  task automatic t_single_write();
    logic oeAny;
    writeOne(mkCmd(0, 3, 0, 2'b00), 8'hA5, oeAny);
    expR[3] = 8'hA5;
    checkAll("R2 single write");
    chk("R5 oe during write", oeAny, 1'b0);
  endtask

  task automatic t_single_read();
    logic [7:0] v; logic oeAll;
    readOne(mkCmd(1, 3, 0, 2'b00), v, oeAll);
    chk("R4 read data", v, 8'hA5);
    chk("R4 oe during read", oeAll, 1'b1);
    chk("R5 oe after deselect", sdoOe, 1'b0);
  endtask

  task automatic t_partial();
    logic [7:0] rb; logic oa, oy;
    sel();
    doBits(mkCmd(0, 4, 0, 2'b00), 8, rb, oa, oy);
    doBits(8'h3C, 7, rb, oa, oy);
    desel();
    checkAll("R3 partial byte");
  endtask

  task automatic t_bad_cmd();
    logic oeAny; logic [7:0] v; logic oeAll;
    writeOne(mkCmd(0, 2, 0, 2'b01), 8'hFF, oeAny);
    checkAll("R6 bad command write");
    readOne(mkCmd(1, 3, 0, 2'b10), v, oeAll);
    chk("R6 bad command read oe", oeAll, 1'b0);
  endtask

  task automatic t_reserved();
    logic oeAny; logic [7:0] v; logic oeAll;
    writeOne(mkCmd(0, 5, 0, 2'b00), 8'hFF, oeAny);
    writeOne(mkCmd(0, 6, 0, 2'b00), 8'hFF, oeAny);
    expR[5] = 8'h3F; expR[6] = 8'h7F;
    checkAll("R7 reserved bits");
    readOne(mkCmd(1, 6, 0, 2'b00), v, oeAll);
    chk("R7 reserved readback", v, 8'h7F);
  endtask

  task automatic t_status();
    logic oeAny; logic [7:0] v; logic oeAll;
    readOne(mkCmd(1, 0, 0, 2'b00), v, oeAll);
    chk("R8 status read", v, 8'h5C);
    writeOne(mkCmd(0, 0, 0, 2'b00), 8'h11, oeAny);
    checkAll("R8 status write ignored");
    statusIn = 8'hE3;
    readOne(mkCmd(1, 0, 0, 2'b00), v, oeAll);
    chk("R8 status follows input", v, 8'hE3);
  endtask

  task automatic t_high_addr();
    logic oeAny; logic [7:0] v; logic oeAll;
    writeOne(mkCmd(0, 14, 0, 2'b00), 8'h99, oeAny);
    checkAll("R12 write addr 14");
    readOne(mkCmd(1, 15, 0, 2'b00), v, oeAll);
    chk("R12 read addr 15", v, 8'h00);
  endtask

  task automatic t_burst_nonzero();
    logic [7:0] rb; logic oa, oy;
    sel();
    doBits(mkCmd(0, 2, 1, 2'b00), 8, rb, oa, oy);
    doBits(8'h77, 8, rb, oa, oy);
    doBits(8'h66, 8, rb, oa, oy);
    desel();
    expR[2] = 8'h77;
    checkAll("R10 burst flag nonzero addr");
  endtask

  task automatic t_burst_write();
    logic [7:0] rb; logic oa, oy, oeAny;
    sel();
    doBits(mkCmd(0, 0, 1, 2'b00), 8, rb, oa, oy);
    oeAny = oy;
    for (int k = 0; k < NREG; k++) begin
      logic [7:0] val;
      val = 8'(8'hC0 + k * 7);
      doBits(val, 8, rb, oa, oy);
      oeAny |= oy;
      if (k > 0) expR[k] = val & keepMask(k);
    end
    doBits(8'hEE, 8, rb, oa, oy);
    oeAny |= oy;
    desel();
    checkAll("R9 burst write");
    chk("R11 extra byte no write reg1", getReg(1), expR[1]);
    chk("R5 oe during burst write", oeAny, 1'b0);
  endtask

  task automatic t_burst_read();
    logic [7:0] rb, v; logic oa, oy, oeAll;
    sel();
    doBits(mkCmd(1, 0, 1, 2'b00), 8, rb, oa, oy);
    for (int k = 0; k < NREG; k++) begin
      doBits(8'h00, 8, v, oeAll, oy);
      chk($sformatf("R9 burst read addr %0d", k), v, (k == 0) ? statusIn : expR[k]);
      chk("R4 oe during burst read", oeAll, 1'b1);
    end
    doBits(8'h00, 8, v, oa, oy);
    chk("R11 oe after burst end", oy, 1'b0);
    desel();
  endtask

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin : main
    for (int k = 0; k < NREG; k++) expR[k] = 8'h00;
    #(CLK_PERIOD*5 + 3);
    rstN = 1'b1;
    #(CLK_PERIOD*5);
    t_reset();
    t_single_write();
    t_single_read();
    t_partial();
    t_bad_cmd();
    t_reserved();
    t_status();
    t_high_addr();
    t_burst_nonzero();
    t_burst_write();
    t_burst_read();
    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule